// File: doc/BRIEF.md
# Single-Cycle Control Decoder

This block is the purely combinational control unit of a single-cycle integer core. It takes the 32-bit instruction word and two flags from an external operand comparator (equal, less-than). From these it produces every select signal the datapath needs for one instruction:

- which immediate format to build;
- whether the register file is written;
- which operands feed the ALU and which ALU operation runs;
- whether the comparator works unsigned;
- whether data memory is written;
- which source is written back;
- whether the next PC is the ALU result or PC+4.

It decodes these instruction classes: register-register arithmetic, register-immediate arithmetic, word load, word store, six conditional branches, PC-relative jump-and-link, and register-indirect jump-and-link. Any other encoding, including unsupported sub-codes of a supported class, becomes a safe no-op. A no-op writes no register, writes no memory, and advances to PC+4. Immediate construction, the ALU, the comparator and the register file all sit outside this block.

The comparator mode output depends only on the instruction word. The branch decision is then taken from the comparator flags in the same cycle.

Top module: `cyc1_ctrl_decoder`

## Requirements
- R1: Register-register class (opcode bits [6:0] = 0110011) drives the following, with the ALU operation chosen by R2: rf_we_o=1, opa_pc_o=0, opb_imm_o=0, wb_src_o=1 (ALU), imm_fmt_o=0, dmem_we_o=0, pc_jump_o=0. Within this class, inst[30]=1 selects SUB for funct3 (inst[14:12]) 000 and SRA for funct3 101.
- R2: ALU operation codes are ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9. funct3 000/001/010/011/100/101/110/111 maps to ADD(or SUB)/SLL/SLT/SLTU/XOR/SRL(or SRA)/OR/AND.
- R3: With STRICT_FUNCT7=1 (default), a register-register word is accepted only in two cases: funct7 (inst[31:25]) is 0000000, or funct7 is 0100000 with funct3 000 or 101. Any other funct7 decodes as unsupported (R9).
- R4: Register-immediate class (0010011) drives imm_fmt_o=0 (I), rf_we_o=1, opb_imm_o=1, opa_pc_o=0, wb_src_o=1, with the ALU operation from funct3 per R2. Here inst[30] selects SRA only for funct3 101; for every other funct3 it has no effect, so funct3 000 is always ADD.
- R5: Word load (0000011, funct3 010) drives imm_fmt_o=0, rf_we_o=1, opb_imm_o=1, opa_pc_o=0, alu ADD, dmem_we_o=0, wb_src_o=0 (memory), pc_jump_o=0.
- R6: Word store (0100011, funct3 010) drives imm_fmt_o=1 (S), rf_we_o=0, opb_imm_o=1, opa_pc_o=0, alu ADD, dmem_we_o=1, wb_src_o=1, pc_jump_o=0.
- R7: Branch class (1100011) drives imm_fmt_o=2 (B), rf_we_o=0, opa_pc_o=1, opb_imm_o=1, alu ADD, dmem_we_o=0, wb_src_o=1. cmp_unsigned_o=1 only for funct3 110 and 111.
- R8: pc_jump_o for a branch is 1 exactly in these cases, and 0 for funct3 010 and 011:
  - funct3 000 (equal) when cmp_eq_i=1;
  - funct3 001 (not equal) when cmp_eq_i=0;
  - funct3 100 or 110 (less-than) when cmp_lt_i=1;
  - funct3 101 or 111 (greater-or-equal) when cmp_lt_i=0.
- R9: An unsupported word drives the safe default: imm_fmt_o=0, rf_we_o=0, opb_imm_o=0, opa_pc_o=0, alu ADD, cmp_unsigned_o=0, dmem_we_o=0, wb_src_o=1, pc_jump_o=0.
- R10: Load or store with funct3 other than 010, and register-indirect jump with funct3 other than 000, are unsupported (R9).
- R11: PC-relative jump (1101111) drives imm_fmt_o=3 (J), rf_we_o=1, opa_pc_o=1, opb_imm_o=1, alu ADD, wb_src_o=2 (PC+4), pc_jump_o=1, whatever the comparator flags are.
- R12: Register-indirect jump (1100111, funct3 000) drives imm_fmt_o=0, rf_we_o=1, opa_pc_o=0, opb_imm_o=1, alu ADD, wb_src_o=2, pc_jump_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | 32 | Instruction word |
| cmp_eq_i | input | 1 | Comparator: operands equal |
| cmp_lt_i | input | 1 | Comparator: operand A less than B |
| imm_fmt_o | output | 2 | Immediate format: 0 I, 1 S, 2 B, 3 J |
| rf_we_o | output | 1 | Register file write enable |
| opb_imm_o | output | 1 | ALU B operand: 1 immediate, 0 rs2 |
| opa_pc_o | output | 1 | ALU A operand: 1 PC, 0 rs1 |
| alu_op_o | output | ALU_SEL_W | ALU operation code |
| cmp_unsigned_o | output | 1 | Comparator works unsigned |
| dmem_we_o | output | 1 | Data memory write enable |
| wb_src_o | output | 2 | Write-back source: 0 memory, 1 ALU, 2 PC+4 |
| pc_jump_o | output | 1 | Next PC: 1 ALU result, 0 PC+4 |

## Verification
Register-register words are applied with each funct3 and with inst[30] both low and high. This separates ADD from SUB and SRL from SRA. Foreign funct7 values show that strict decoding rejects them. Register-immediate words carry immediates with bit 30 set, so a decoder that wrongly lets that bit turn ADDI into SUB, or XORI into something else, is caught. Every branch condition is driven with both flag values, which separates taken from not-taken and each signed branch from its unsigned twin. Jumps are driven with varying flags to show the flags have no effect there, and near-miss encodings (other load widths, unused branch codes, a register-indirect jump with non-zero funct3) show the fallback to the safe default.

// File: rtl/cyc1_ctrl_pkg.sv
package cyc1_ctrl_pkg;

   typedef enum logic [6:0] {
      OPC_REG    = 7'b0110011,
      OPC_IMM    = 7'b0010011,
      OPC_LOAD   = 7'b0000011,
      OPC_STORE  = 7'b0100011,
      OPC_BRANCH = 7'b1100011,
      OPC_JUMP   = 7'b1101111,
      OPC_JIND   = 7'b1100111
   } opcode_e;

   typedef enum logic [2:0] {
      CLS_NONE,
      CLS_REG,
      CLS_IMM,
      CLS_LOAD,
      CLS_STORE,
      CLS_BRANCH,
      CLS_JUMP,
      CLS_JIND
   } ins_class_e;

   typedef enum logic [1:0] {
      IMM_I = 2'd0,
      IMM_S = 2'd1,
      IMM_B = 2'd2,
      IMM_J = 2'd3
   } imm_fmt_e;

   typedef enum logic [3:0] {
      ALU_ADD  = 4'd0,
      ALU_SUB  = 4'd1,
      ALU_SLL  = 4'd2,
      ALU_SLT  = 4'd3,
      ALU_SLTU = 4'd4,
      ALU_XOR  = 4'd5,
      ALU_SRL  = 4'd6,
      ALU_SRA  = 4'd7,
      ALU_OR   = 4'd8,
      ALU_AND  = 4'd9
   } alu_op_e;

   typedef enum logic [1:0] {
      WB_MEM  = 2'd0,
      WB_ALU  = 2'd1,
      WB_LINK = 2'd2
   } wb_src_e;

   localparam int unsigned INST_W   = 32;
   localparam int unsigned ALU_CODE_W = 4;

   localparam logic [2:0] F3_WORD   = 3'b010;
   localparam logic [2:0] F3_ADDSUB = 3'b000;
   localparam logic [2:0] F3_SHR    = 3'b101;
   localparam logic [6:0] F7_BASE   = 7'b0000000;
   localparam logic [6:0] F7_ALT    = 7'b0100000;

   typedef struct packed {
      imm_fmt_e imm_fmt;
      logic     rf_we;
      logic     opb_imm;
      logic     opa_pc;
      logic     dmem_we;
      wb_src_e  wb_src;
      logic     uses_alu_map;
      logic     is_branch;
      logic     always_jump;
   } ctrl_word_t;

endpackage

// File: rtl/cyc1_ctrl_classify.sv
module cyc1_ctrl_classify
   import cyc1_ctrl_pkg::*;
#(
   parameter bit STRICT_FUNCT7 = 1'b1
) (
   input  logic [INST_W-1:0] inst_i,
   output ins_class_e        cls_o
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic [6:0] f7;
   logic       reg_ok;

   assign opc = inst_i[6:0];
   assign f3  = inst_i[14:12];
   assign f7  = inst_i[31:25];

   generate
      if (STRICT_FUNCT7) begin : g_strict
         assign reg_ok = (f7 == F7_BASE) ||
                         ((f7 == F7_ALT) && ((f3 == F3_ADDSUB) || (f3 == F3_SHR)));
      end else begin : g_lenient
         assign reg_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      cls_o = CLS_NONE;
      unique case (opc)
         OPC_REG:    cls_o = reg_ok ? CLS_REG : CLS_NONE;
         OPC_IMM:    cls_o = CLS_IMM;
         OPC_LOAD:   cls_o = (f3 == F3_WORD) ? CLS_LOAD : CLS_NONE;
         OPC_STORE:  cls_o = (f3 == F3_WORD) ? CLS_STORE : CLS_NONE;
         OPC_BRANCH: cls_o = CLS_BRANCH;
         OPC_JUMP:   cls_o = CLS_JUMP;
         OPC_JIND:   cls_o = (f3 == 3'b000) ? CLS_JIND : CLS_NONE;
         default:    cls_o = CLS_NONE;
      endcase
   end

endmodule

// File: rtl/cyc1_ctrl_alu_map.sv
module cyc1_ctrl_alu_map
   import cyc1_ctrl_pkg::*;
(
   input  ins_class_e cls_i,
   input  logic [2:0] f3_i,
   input  logic       bit30_i,
   output alu_op_e    op_o
);

   logic alt;

   // Register-register: bit 30 picks SUB/SRA; immediate form: only SRA.
   assign alt = (cls_i == CLS_REG) ? bit30_i
                                   : ((f3_i == F3_SHR) && bit30_i);

   always_comb begin
      op_o = ALU_ADD;
      if ((cls_i == CLS_REG) || (cls_i == CLS_IMM)) begin
         unique case (f3_i)
            3'b000: op_o = alt ? ALU_SUB : ALU_ADD;
            3'b001: op_o = ALU_SLL;
            3'b010: op_o = ALU_SLT;
            3'b011: op_o = ALU_SLTU;
            3'b100: op_o = ALU_XOR;
            3'b101: op_o = alt ? ALU_SRA : ALU_SRL;
            3'b110: op_o = ALU_OR;
            3'b111: op_o = ALU_AND;
            default: op_o = ALU_ADD;
         endcase
      end
   end

endmodule

// File: rtl/cyc1_ctrl_branch_eval.sv
module cyc1_ctrl_branch_eval
   import cyc1_ctrl_pkg::*;
(
   input  logic       enable_i,
   input  logic [2:0] f3_i,
   input  logic       eq_i,
   input  logic       lt_i,
   output logic       taken_o,
   output logic       unsigned_o
);

   logic cond;

   // f3[2]=0: equality tests, f3[2]=1: ordering tests; f3[0] inverts.
   always_comb begin
      cond = 1'b0;
      unique case (f3_i)
         3'b000, 3'b001:                 cond = eq_i ^ f3_i[0];
         3'b100, 3'b101, 3'b110, 3'b111: cond = lt_i ^ f3_i[0];
         default:                        cond = 1'b0;
      endcase
   end

   assign taken_o    = enable_i && cond;
   assign unsigned_o = enable_i && f3_i[2] && f3_i[1];

endmodule

// File: rtl/cyc1_ctrl_decoder.sv
module cyc1_ctrl_decoder
   import cyc1_ctrl_pkg::*;
#(
   parameter int unsigned ALU_SEL_W     = 4,
   parameter bit          STRICT_FUNCT7 = 1'b1
) (
   input  logic [31:0]          inst_i,
   input  logic                 cmp_eq_i,
   input  logic                 cmp_lt_i,
   output logic [1:0]           imm_fmt_o,
   output logic                 rf_we_o,
   output logic                 opb_imm_o,
   output logic                 opa_pc_o,
   output logic [ALU_SEL_W-1:0] alu_op_o,
   output logic                 cmp_unsigned_o,
   output logic                 dmem_we_o,
   output logic [1:0]           wb_src_o,
   output logic                 pc_jump_o
);

   localparam int unsigned PAD_W = (ALU_SEL_W > ALU_CODE_W) ? ALU_SEL_W - ALU_CODE_W : 1;

   generate
      if (ALU_SEL_W < ALU_CODE_W) begin : g_bad_width
         $error("ALU_SEL_W must hold every ALU operation code");
      end
   endgenerate

   ins_class_e cls;
   alu_op_e    alu_op;
   ctrl_word_t cw;
   logic       br_taken;
   logic       br_unsigned;

   cyc1_ctrl_classify #(
      .STRICT_FUNCT7 (STRICT_FUNCT7)
   ) u_classify (
      .inst_i (inst_i),
      .cls_o  (cls)
   );

   cyc1_ctrl_alu_map u_alu_map (
      .cls_i   (cls),
      .f3_i    (inst_i[14:12]),
      .bit30_i (inst_i[30]),
      .op_o    (alu_op)
   );

   cyc1_ctrl_branch_eval u_branch (
      .enable_i   (cls == CLS_BRANCH),
      .f3_i       (inst_i[14:12]),
      .eq_i       (cmp_eq_i),
      .lt_i       (cmp_lt_i),
      .taken_o    (br_taken),
      .unsigned_o (br_unsigned)
   );

   // Per-class control word; the default entry is the safe no-op.
   always_comb begin
      cw = '{imm_fmt: IMM_I, rf_we: 1'b0, opb_imm: 1'b0, opa_pc: 1'b0,
             dmem_we: 1'b0, wb_src: WB_ALU, uses_alu_map: 1'b0,
             is_branch: 1'b0, always_jump: 1'b0};
      unique case (cls)
         CLS_REG: begin
            cw.rf_we        = 1'b1;
            cw.uses_alu_map = 1'b1;
         end
         CLS_IMM: begin
            cw.rf_we        = 1'b1;
            cw.opb_imm      = 1'b1;
            cw.uses_alu_map = 1'b1;
         end
         CLS_LOAD: begin
            cw.rf_we   = 1'b1;
            cw.opb_imm = 1'b1;
            cw.wb_src  = WB_MEM;
         end
         CLS_STORE: begin
            cw.imm_fmt = IMM_S;
            cw.opb_imm = 1'b1;
            cw.dmem_we = 1'b1;
         end
         CLS_BRANCH: begin
            cw.imm_fmt   = IMM_B;
            cw.opb_imm   = 1'b1;
            cw.opa_pc    = 1'b1;
            cw.is_branch = 1'b1;
         end
         CLS_JUMP: begin
            cw.imm_fmt     = IMM_J;
            cw.rf_we       = 1'b1;
            cw.opb_imm     = 1'b1;
            cw.opa_pc      = 1'b1;
            cw.wb_src      = WB_LINK;
            cw.always_jump = 1'b1;
         end
         CLS_JIND: begin
            cw.rf_we       = 1'b1;
            cw.opb_imm     = 1'b1;
            cw.wb_src      = WB_LINK;
            cw.always_jump = 1'b1;
         end
         default: ;
      endcase
   end

   assign imm_fmt_o      = cw.imm_fmt;
   assign rf_we_o        = cw.rf_we;
   assign opb_imm_o      = cw.opb_imm;
   assign opa_pc_o       = cw.opa_pc;
   assign dmem_we_o      = cw.dmem_we;
   assign wb_src_o       = cw.wb_src;
   assign cmp_unsigned_o = br_unsigned;
   assign pc_jump_o      = cw.always_jump || (cw.is_branch && br_taken);

   generate
      if (ALU_SEL_W > ALU_CODE_W) begin : g_wide
         logic [PAD_W-1:0] pad;
         assign pad      = '0;
         assign alu_op_o = {pad, (cw.uses_alu_map ? alu_op : ALU_ADD)};
      end else begin : g_exact
         assign alu_op_o = cw.uses_alu_map ? alu_op : ALU_ADD;
      end
   endgenerate

endmodule

// File: rtl/cyc1_ctrl_decoder_chk.sv
module cyc1_ctrl_decoder_chk #(
   parameter int unsigned ALU_SEL_W = 4
) (
   input logic [31:0]          inst_i,
   input logic                 cmp_eq_i,
   input logic                 cmp_lt_i,
   input logic [1:0]           imm_fmt_o,
   input logic                 rf_we_o,
   input logic                 opb_imm_o,
   input logic                 opa_pc_o,
   input logic [ALU_SEL_W-1:0] alu_op_o,
   input logic                 cmp_unsigned_o,
   input logic                 dmem_we_o,
   input logic [1:0]           wb_src_o,
   input logic                 pc_jump_o
);

   logic [6:0] opc;
   logic       known;

   assign opc   = inst_i[6:0];
   assign known = (opc == 7'b0110011) || (opc == 7'b0010011) ||
                  (opc == 7'b0000011) || (opc == 7'b0100011) ||
                  (opc == 7'b1100011) || (opc == 7'b1101111) ||
                  (opc == 7'b1100111);

   always_comb begin
      if (!$isunknown(inst_i) && !known) begin
         a_r9_unknown_is_noop: assert (!rf_we_o && !dmem_we_o && !pc_jump_o)
            else $error("unsupported opcode changed state");
      end
      if (!$isunknown(inst_i) && dmem_we_o) begin
         a_r6_store_only: assert (opc == 7'b0100011 && !rf_we_o && imm_fmt_o == 2'd1)
            else $error("memory write outside store");
      end
      if (!$isunknown(inst_i) && opc == 7'b1100011) begin
         a_r7_branch_no_wb: assert (!rf_we_o && !dmem_we_o && opa_pc_o && imm_fmt_o == 2'd2)
            else $error("branch control word wrong");
      end
      if (!$isunknown(inst_i) && cmp_unsigned_o) begin
         a_r8_unsigned_only: assert (opc == 7'b1100011 && inst_i[14:13] == 2'b11)
            else $error("unsigned compare outside unsigned branch");
      end
      if (!$isunknown(inst_i) && opc == 7'b1101111) begin
         a_r11_jump_always: assert (pc_jump_o && rf_we_o && wb_src_o == 2'd2)
            else $error("jump did not redirect");
      end
      if (!$isunknown(inst_i) && (opc == 7'b0110011 || opc == 7'b0010011) && rf_we_o) begin
         a_r2_alu_code_range: assert (alu_op_o <= ALU_SEL_W'(9))
            else $error("ALU code out of range");
      end
   end

endmodule

bind cyc1_ctrl_decoder cyc1_ctrl_decoder_chk #(
   .ALU_SEL_W (ALU_SEL_W)
) u_chk (
   .inst_i         (inst_i),
   .cmp_eq_i       (cmp_eq_i),
   .cmp_lt_i       (cmp_lt_i),
   .imm_fmt_o      (imm_fmt_o),
   .rf_we_o        (rf_we_o),
   .opb_imm_o      (opb_imm_o),
   .opa_pc_o       (opa_pc_o),
   .alu_op_o       (alu_op_o),
   .cmp_unsigned_o (cmp_unsigned_o),
   .dmem_we_o      (dmem_we_o),
   .wb_src_o       (wb_src_o),
   .pc_jump_o      (pc_jump_o)
);

// File: tb/cyc1_ctrl_decoder_bench.sv
`timescale 1ns/1ps
module cyc1_ctrl_decoder_bench;

   logic        clk = 1'b0;
   logic [31:0] inst;
   logic        eq, lt;
   logic [1:0]  imm_fmt, wb_src;
   logic        rf_we, opb_imm, opa_pc, cmp_un, dmem_we, pc_jump;
   logic [3:0]  alu_op;
   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;

   always #2.5 clk = ~clk;

   cyc1_ctrl_decoder u_cyc1_ctrl_decoder (
      .inst_i (inst), .cmp_eq_i (eq), .cmp_lt_i (lt),
      .imm_fmt_o (imm_fmt), .rf_we_o (rf_we), .opb_imm_o (opb_imm),
      .opa_pc_o (opa_pc), .alu_op_o (alu_op), .cmp_unsigned_o (cmp_un),
      .dmem_we_o (dmem_we), .wb_src_o (wb_src), .pc_jump_o (pc_jump)
   );

   // field order: imm, we, b, a, alu, un, mw, wb, pc
   function automatic logic [14:0] cw(input logic [1:0] imm, input logic we,
         input logic b, input logic a, input logic [3:0] alu, input logic un,
         input logic mw, input logic [1:0] wb, input logic pc);
      return {imm, we, b, a, alu, un, mw, wb, pc};
   endfunction

   localparam logic [14:0] NOOP = {2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd1, 1'b0};

   function automatic logic [31:0] rr(input logic [6:0] f7, input logic [2:0] f3);
      return {f7, 5'd2, 5'd1, f3, 5'd3, 7'b0110011};
   endfunction
   function automatic logic [31:0] ri(input logic [11:0] imm, input logic [2:0] f3,
                                      input logic [6:0] op);
      return {imm, 5'd1, f3, 5'd3, op};
   endfunction
   function automatic logic [31:0] br(input logic [2:0] f3);
      return {7'b1000000, 5'd2, 5'd1, f3, 5'b00110, 7'b1100011};
   endfunction

   task automatic check(input string req, input logic [31:0] i, input logic e,
                        input logic l, input logic [14:0] exp);
      logic [14:0] got;
      @(negedge clk);
      inst = i; eq = e; lt = l;
      #1;
      got = {imm_fmt, rf_we, opb_imm, opa_pc, alu_op, cmp_un, dmem_we, wb_src, pc_jump};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s inst=%h eq=%b lt=%b actual=%b expected=%b",
                  req, i, e, l, got, exp);
      end
   endtask

   task automatic t_reset_state;
      check("R9 idle", 32'h0, 1'b0, 1'b0, NOOP);
      check("R9 unknown opcode", 32'hFFFF_FF7F, 1'b1, 1'b1, NOOP);
   endtask

   task automatic t_reg;
      check("R1 add", rr(7'h00, 3'b000), 0, 0, cw(0,1,0,0,4'd0,0,0,1,0));
      check("R1 sub", rr(7'h20, 3'b000), 0, 0, cw(0,1,0,0,4'd1,0,0,1,0));
      check("R2 sll", rr(7'h00, 3'b001), 0, 0, cw(0,1,0,0,4'd2,0,0,1,0));
      check("R2 slt", rr(7'h00, 3'b010), 0, 0, cw(0,1,0,0,4'd3,0,0,1,0));
      check("R2 sltu", rr(7'h00, 3'b011), 0, 0, cw(0,1,0,0,4'd4,0,0,1,0));
      check("R2 xor", rr(7'h00, 3'b100), 0, 0, cw(0,1,0,0,4'd5,0,0,1,0));
      check("R1 srl", rr(7'h00, 3'b101), 0, 0, cw(0,1,0,0,4'd6,0,0,1,0));
      check("R1 sra", rr(7'h20, 3'b101), 0, 0, cw(0,1,0,0,4'd7,0,0,1,0));
      check("R2 or", rr(7'h00, 3'b110), 0, 0, cw(0,1,0,0,4'd8,0,0,1,0));
      check("R2 and", rr(7'h00, 3'b111), 0, 0, cw(0,1,0,0,4'd9,0,0,1,0));
      check("R3 funct7 01", rr(7'h01, 3'b000), 0, 0, NOOP);
      check("R3 alt with and", rr(7'h20, 3'b111), 0, 0, NOOP);
   endtask

   task automatic t_imm;
      check("R4 addi bit30", ri(12'h400, 3'b000, 7'b0010011), 0, 0, cw(0,1,1,0,4'd0,0,0,1,0));
      check("R4 xori bit30", ri(12'h7FF, 3'b100, 7'b0010011), 0, 0, cw(0,1,1,0,4'd5,0,0,1,0));
      check("R4 srli", ri(12'h003, 3'b101, 7'b0010011), 0, 0, cw(0,1,1,0,4'd6,0,0,1,0));
      check("R4 srai", ri(12'h403, 3'b101, 7'b0010011), 0, 0, cw(0,1,1,0,4'd7,0,0,1,0));
      check("R4 sltiu", ri(12'hFFF, 3'b011, 7'b0010011), 0, 0, cw(0,1,1,0,4'd4,0,0,1,0));
   endtask

   task automatic t_mem;
      check("R5 word load", ri(12'h008, 3'b010, 7'b0000011), 1, 1, cw(0,1,1,0,4'd0,0,0,0,0));
      check("R6 word store", ri(12'h408, 3'b010, 7'b0100011), 1, 0, cw(1,0,1,0,4'd0,0,1,1,0));
      check("R10 byte load", ri(12'h008, 3'b000, 7'b0000011), 0, 0, NOOP);
      check("R10 half store", ri(12'h008, 3'b001, 7'b0100011), 0, 0, NOOP);
   endtask

   task automatic t_branch;
      for (int f = 0; f < 8; f++) begin
         for (int fl = 0; fl < 4; fl++) begin
            logic e, l, tk, un;
            e = fl[1]; l = fl[0];
            un = (f == 6) || (f == 7);
            case (f)
               0: tk = e;
               1: tk = !e;
               4, 6: tk = l;
               5, 7: tk = !l;
               default: tk = 1'b0;
            endcase
            check(tk ? "R8 branch taken" : "R7 branch not taken", br(3'(f)), e, l,
                  cw(2,0,1,1,4'd0,un,0,1,tk));
         end
      end
   endtask

   task automatic t_jump;
      for (int fl = 0; fl < 4; fl++) begin
         check("R11 jump", {20'hABCDE, 5'd1, 7'b1101111}, fl[1], fl[0],
               cw(3,1,1,1,4'd0,0,0,2,1));
      end
      check("R12 indirect", ri(12'h004, 3'b000, 7'b1100111), 0, 1, cw(0,1,1,0,4'd0,0,0,2,1));
      check("R10 indirect f3", ri(12'h004, 3'b001, 7'b1100111), 1, 0, NOOP);
   endtask

   initial begin
      inst = 32'h0; eq = 1'b0; lt = 1'b0;
      t_reset_state();
      t_reg();
      t_imm();
      t_mem();
      t_branch();
      t_jump();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule